// File: doc/BRIEF.md
# External Bus Strobe Sequencer with Byte Enables

This block turns single internal bus requests into timed external bus cycles. It drives one address strobe, one chip select per area, a read strobe and one write strobe shared by all bytes. It also drives four active-low byte-lane lines and a 16-bit data path with an output enable. Each request carries an area number, a 32-bit address, a 4-bit byte mask, a read/write flag and write data. Read data comes back with a one-cycle done pulse.

Each area has its own configuration: a 4-bit type code, a 4-bit wait count, a bit that delays the strobes by one cycle, a read-to-write idle count and a write recovery count. Type bit 1 picks how the byte lanes behave. In byte-enable mode (codes of the form 0x1x) the lanes mark the accessed bytes for the whole access, on reads and on writes. In per-byte strobe mode (codes of the form 0x0x) the lanes act as separate write strobes. When both families are configured with type bit 3 clear, the block never lets a turnaround or recovery gap fall below one cycle.

Top module: `extbus_strobe_seq`

## Requirements
- R1: An access lasts 2 + D + W cycles, where W is the area's wait count and D its delay bit. The selected area's chip select is low for all of them, the others stay high, and the address strobe is low only in the first cycle.
- R2: The read strobe (on reads) or the shared write strobe (on writes in byte-enable mode) goes low in cycle 2 + D of the access. It stays low for W + 1 cycles and ends with the access.
- R3: For an area whose type has bit 3 = 0 and bit 1 = 1, the byte lanes carry the inverted request mask (lane n low when mask bit n is 1) from the first cycle to the last, on reads and writes.
- R4: For an area whose type has bit 1 = 0, the byte lanes carry the inverted mask only during the strobe cycles of a write and are high otherwise. The shared write strobe stays high.
- R5: On a write the data output enable is high, with the request's write data on the data lines, exactly in the strobe cycles. It is low at all other times.
- R6: Read data is sampled at the clock edge that ends the last strobe cycle. It is presented with a done pulse one cycle wide in the cycle after the access, and done also pulses after writes.
- R7: After a write, the next access starts no earlier than R + 1 cycles after the write ends, where R is the written area's recovery count.
- R8: A write that follows a read starts no earlier than I + 1 cycles after the read ends, where I is the read area's idle count. Read after read, and write or read after write with R = 0, need only the one cycle.
- R9: When some area has a type with bit 3 = 0 and bit 1 = 0 and another has bit 3 = 0 and bit 1 = 1, a zero recovery or idle count acts as 1. Otherwise zero means no extra cycle.
- R10: After reset all strobes, chip selects and byte lanes are high, the output enable is low and the block is ready.
- R11: req_ready is low for the whole of an access and during any gap still required. A request is taken at the clock edge where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_area | input | 2 | Target area |
| req_addr | input | 32 | Access address |
| req_mask | input | 4 | Byte mask, bit n for byte n |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data |
| cfg_type | input | 16 | 4-bit type code per area |
| cfg_wait | input | 16 | 4-bit wait count per area |
| cfg_dly | input | 4 | Strobe delay bit per area |
| cfg_idle | input | 16 | 4-bit read-to-write idle count per area |
| cfg_rec | input | 16 | 4-bit write recovery count per area |
| as_n | output | 1 | Address strobe, active low |
| cs_n | output | 4 | Chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Shared write strobe, active low |
| lane_n | output | 4 | Byte lanes, active low |
| addr_o | output | 32 | External address |
| dq_o | output | 16 | Write data out |
| dq_oe | output | 1 | Data output enable |
| dq_i | input | 16 | Read data in |
| rdata | output | 16 | Captured read data |
| done | output | 1 | Access complete pulse |

## Verification
A queue of back-to-back requests is issued to all four areas. The areas cover wait counts of 0 to 3, with and without the delay bit, and lane masks of 1, 2 and 4 bits, so strobe position and length are told apart from the fixed address strobe. Reads and writes go to both a byte-enable area and a per-byte strobe area. This separates lanes held for the full access from lanes tied to the write strobe, and shows whether the shared write strobe stays high in per-byte mode. The read/write orderings cover read-then-write, write-then-read, write-then-write and read-then-read, under a mixed configuration and then an unmixed one. Measuring the idle gap of each shows whether recovery, turnaround and the forced minimum of one are applied only where they belong.

// File: rtl/extbus_strobe_seq.sv
module extbus_strobe_seq #(
  parameter int NAREA = 4,
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int NL    = 4,
  parameter int WW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [$clog2(NAREA)-1:0]  req_area,
  input  logic [AW-1:0]             req_addr,
  input  logic [NL-1:0]             req_mask,
  input  logic                      req_write,
  input  logic [DW-1:0]             req_wdata,
  input  logic [NAREA*4-1:0]        cfg_type,
  input  logic [NAREA*WW-1:0]       cfg_wait,
  input  logic [NAREA-1:0]          cfg_dly,
  input  logic [NAREA*WW-1:0]       cfg_idle,
  input  logic [NAREA*WW-1:0]       cfg_rec,
  output logic                      as_n,
  output logic [NAREA-1:0]          cs_n,
  output logic                      rd_n,
  output logic                      wr_n,
  output logic [NL-1:0]             lane_n,
  output logic [AW-1:0]             addr_o,
  output logic [DW-1:0]             dq_o,
  output logic                      dq_oe,
  input  logic [DW-1:0]             dq_i,
  output logic [DW-1:0]             rdata,
  output logic                      done
);
  localparam int AREA_W = $clog2(NAREA);
  localparam int QW     = WW + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_DLY, S_STB} st_t;

  st_t              st;
  logic [AREA_W-1:0] area, prev_area;
  logic [NL-1:0]    mask;
  logic             wr, last_wr, have_prev;
  logic [DW-1:0]    wdata;
  logic [WW-1:0]    cnt;
  logic [QW-1:0]    quiet;

  logic [NAREA-1:0] fam_pb, fam_be;
  for (genvar i = 0; i < NAREA; i++) begin : g_area
    assign fam_pb[i] = !cfg_type[i*4+3] && !cfg_type[i*4+1];
    assign fam_be[i] = !cfg_type[i*4+3] &&  cfg_type[i*4+1];
    assign cs_n[i]   = !(st != S_IDLE && area == AREA_W'(i));
  end
  wire mixed = (|fam_pb) && (|fam_be);

  wire [WW-1:0] rec_raw  = cfg_rec[prev_area*WW +: WW];
  wire [WW-1:0] idle_raw = cfg_idle[prev_area*WW +: WW];
  wire [WW-1:0] rec_n    = (mixed && rec_raw == '0)  ? WW'(1) : rec_raw;
  wire [WW-1:0] idle_n   = (mixed && idle_raw == '0) ? WW'(1) : idle_raw;
  wire [WW-1:0] need     = !have_prev ? '0 : last_wr ? rec_n : (req_write ? idle_n : '0);

  assign req_ready = (st == S_IDLE) && (quiet >= {1'b0, need});

  wire be_mode = cfg_type[area*4+1];
  wire stb     = (st == S_STB);
  wire active  = (st != S_IDLE);

  assign as_n   = !(st == S_SETUP);
  assign rd_n   = !(stb && !wr);
  assign wr_n   = !(stb && wr && be_mode);
  assign lane_n = be_mode ? (active ? ~mask : '1) : ((stb && wr) ? ~mask : '1);
  assign dq_oe  = stb && wr;
  assign dq_o   = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      area      <= '0;
      prev_area <= '0;
      mask      <= '0;
      wr        <= 1'b0;
      last_wr   <= 1'b0;
      have_prev <= 1'b0;
      wdata     <= '0;
      addr_o    <= '0;
      cnt       <= '0;
      quiet     <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (quiet != '1) quiet <= quiet + 1'b1;
          if (req_valid && req_ready) begin
            st     <= S_SETUP;
            area   <= req_area;
            addr_o <= req_addr;
            mask   <= req_mask;
            wr     <= req_write;
            wdata  <= req_wdata;
          end
        end
        S_SETUP: begin
          cnt <= cfg_wait[area*WW +: WW];
          st  <= cfg_dly[area] ? S_DLY : S_STB;
        end
        S_DLY: st <= S_STB;
        S_STB: begin
          if (cnt == '0) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            quiet     <= '0;
            last_wr   <= wr;
            prev_area <= area;
            have_prev <= 1'b1;
            if (!wr) rdata <= dq_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_AS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !as_n |=> as_n); // R1
  AST_AS_WITH_CS:   assert property (@(posedge clk) disable iff (!rst_n) !as_n |-> (cs_n != '1)); // R1
  AST_CS_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R1
  AST_STB_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R2
  AST_STB_IN_CS:    assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> (cs_n != '1)); // R2
  AST_OE_NO_READ:   assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> rd_n); // R5
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n == '1)); // R6
  AST_BUSY_NREADY:  assert property (@(posedge clk) disable iff (!rst_n) (cs_n != '1) |-> !req_ready); // R11
endmodule

// File: tb/extbus_strobe_seq_tb.sv
`timescale 1ns/100ps
module extbus_strobe_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_area = '0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_mask = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] cfg_type, cfg_wait, cfg_idle, cfg_rec;
  logic [3:0]  cfg_dly;
  logic        req_ready, as_n, rd_n, wr_n, dq_oe, done;
  logic [3:0]  cs_n, lane_n;
  logic [31:0] addr_o;
  logic [15:0] dq_o, dq_i, rdata;

  assign dq_i = addr_o[15:0] ^ 16'h5A3C;

  extbus_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_addr(req_addr), .req_mask(req_mask),
    .req_write(req_write), .req_wdata(req_wdata),
    .cfg_type(cfg_type), .cfg_wait(cfg_wait), .cfg_dly(cfg_dly),
    .cfg_idle(cfg_idle), .cfg_rec(cfg_rec),
    .as_n(as_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .lane_n(lane_n),
    .addr_o(addr_o), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i),
    .rdata(rdata), .done(done)
  );

  typedef struct {
    int total; int cs; int stb_start; int stb_cnt; int lane_start; int lane_cnt;
    int lane_val; int wr_cnt; int oe_cnt; int dout; int rd; int rdv; int gap; int gtag;
  } item_t;
  item_t q[$];

  int n_cmp = 0, n_bad = 0;
  int prev_valid = 0, prev_wr = 0, prev_area = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string gname(int g);
    case (g)
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit is_mixed();
    bit pb = 0, be = 0;
    for (int i = 0; i < 4; i++) begin
      if (!cfg_type[i*4+3] && !cfg_type[i*4+1]) pb = 1;
      if (!cfg_type[i*4+3] &&  cfg_type[i*4+1]) be = 1;
    end
    return pb && be;
  endfunction

  task automatic issue(int area, int addr, int mask, int w, int wd);
    item_t it;
    int wt, d, bm, need, raw, tag;
    wt = cfg_wait[area*4 +: 4];
    d  = cfg_dly[area];
    bm = cfg_type[area*4+1];
    it.total = 2 + d + wt;
    it.cs = area;
    it.rd = !w;
    it.rdv = (addr & 16'hFFFF) ^ 16'h5A3C;
    it.oe_cnt = w ? wt + 1 : 0;
    it.dout = w ? wd : 0;
    it.wr_cnt = (w && bm) ? wt + 1 : 0;
    if (!w || bm) begin it.stb_start = 2 + d; it.stb_cnt = wt + 1; end
    else begin it.stb_start = 0; it.stb_cnt = 0; end
    if (bm) begin it.lane_start = 1; it.lane_cnt = it.total; it.lane_val = ~mask & 4'hF; end
    else if (w) begin it.lane_start = 2 + d; it.lane_cnt = wt + 1; it.lane_val = ~mask & 4'hF; end
    else begin it.lane_start = 0; it.lane_cnt = 0; it.lane_val = 0; end
    need = 0; tag = 8;
    if (prev_wr) begin raw = cfg_rec[prev_area*4 +: 4]; tag = 7; end
    else if (w) begin raw = cfg_idle[prev_area*4 +: 4]; tag = 8; end
    else raw = -1;
    if (raw >= 0) begin
      need = raw;
      if (is_mixed() && raw == 0) begin need = 1; tag = 9; end
      else if (raw == 0) tag = 9;
    end
    it.gap = prev_valid ? need + 1 : -1;
    it.gtag = tag;
    q.push_back(it);
    prev_valid = 1; prev_wr = w; prev_area = area;
    req_area = 2'(area); req_addr = 32'(addr); req_mask = 4'(mask);
    req_write = w[0]; req_wdata = 16'(wd); req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    prev_valid = 0;
  endtask

  int idx = 0, idle_run = 0, gap_meas = -1;
  int m_stb_s, m_stb_c, m_ln_s, m_ln_c, m_ln_v, m_wr_c, m_oe_c, m_dout, m_cs, m_as;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n != 4'hF) begin
        idx++;
        if (idx == 1) begin
          gap_meas = idle_run;
          m_stb_s = 0; m_stb_c = 0; m_ln_s = 0; m_ln_c = 0; m_ln_v = 0;
          m_wr_c = 0; m_oe_c = 0; m_dout = 0; m_as = 0;
          m_cs = (!cs_n[0]) ? 0 : (!cs_n[1]) ? 1 : (!cs_n[2]) ? 2 : 3;
          chk("R1 address strobe in first cycle", as_n, 0);
          chk("R11 ready low while busy", req_ready, 0);
        end
        if (!as_n) m_as++;
        if (!rd_n || !wr_n) begin if (m_stb_c == 0) m_stb_s = idx; m_stb_c++; end
        if (!wr_n) m_wr_c++;
        if (lane_n != 4'hF) begin if (m_ln_c == 0) m_ln_s = idx; m_ln_c++; m_ln_v = lane_n; end
        if (dq_oe) begin m_oe_c++; m_dout = dq_o; end
      end else begin
        if (dq_oe) chk("R5 output enable low when idle", 1, 0);
        if (done) begin
          item_t e;
          if (q.size() == 0) chk("R6 unexpected done", 1, 0);
          else begin
            e = q.pop_front();
            chk("R1 access length", idx, e.total);
            chk("R1 address strobe count", m_as, 1);
            chk("R1 chip select", m_cs, e.cs);
            chk("R2 strobe start", m_stb_s, e.stb_start);
            chk("R2 strobe length", m_stb_c, e.stb_cnt);
            chk("R3 R4 lane start", m_ln_s, e.lane_start);
            chk("R3 R4 lane length", m_ln_c, e.lane_cnt);
            chk("R3 R4 lane value", m_ln_v, e.lane_val);
            chk("R4 shared write strobe cycles", m_wr_c, e.wr_cnt);
            chk("R5 output enable cycles", m_oe_c, e.oe_cnt);
            chk("R5 write data", m_dout, e.dout);
            if (e.rd) chk("R6 read data", rdata, e.rdv);
            if (e.gap >= 0) chk(gname(e.gtag), gap_meas, e.gap);
          end
          idle_run = 0;
        end
        if (idx != 0 && !done) chk("R6 done after access", 0, 1);
        idx = 0;
        idle_run++;
      end
    end
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd_cnt, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cfg_type = {4'h8, 4'h0, 4'h3, 4'h2};
    cfg_wait = {4'd3, 4'd1, 4'd0, 4'd2};
    cfg_dly  = 4'b1010;
    cfg_idle = {4'd1, 4'd0, 4'd2, 4'd0};
    cfg_rec  = {4'd0, 4'd0, 4'd3, 4'd0};
    repeat (3) @(negedge clk);
    chk("R10 reset address strobe", as_n, 1);
    chk("R10 reset chip selects", cs_n, 4'hF);
    chk("R10 reset read strobe", rd_n, 1);
    chk("R10 reset write strobe", wr_n, 1);
    chk("R10 reset lanes", lane_n, 4'hF);
    chk("R10 reset output enable", dq_oe, 0);
    chk("R10 reset ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 32'h1000_1234, 4'hF, 0, 0);
    issue(0, 32'h1000_2000, 4'h3, 1, 16'hBEEF);
    issue(1, 32'h2000_0010, 4'hC, 1, 16'h1357);
    issue(1, 32'h2000_0F0F, 4'h1, 0, 0);
    issue(2, 32'h3000_00A0, 4'h6, 1, 16'hC0DE);
    issue(2, 32'h3000_7777, 4'hF, 0, 0);
    issue(3, 32'h4000_0042, 4'h8, 0, 0);
    issue(3, 32'h4000_0044, 4'h5, 1, 16'h0F0F);
    drain();
    cfg_type = {4'h8, 4'h6, 4'h3, 4'h2};
    @(negedge clk);
    issue(0, 32'h1000_0100, 4'h2, 1, 16'h2468);
    issue(0, 32'h1000_0104, 4'h4, 1, 16'hFACE);
    issue(0, 32'h1000_ABCD, 4'h3, 0, 0);
    issue(2, 32'h3000_0200, 4'h9, 1, 16'h5555);
    issue(1, 32'h2000_0300, 4'hF, 1, 16'hAAAA);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule